// File: doc/BRIEF.md
# Clock Distribution Divider Tree

This block is the digital back end of a phase-locked clock driver. It picks one of two reference clocks. It then chooses the clock that feeds a small divider tree. In loop mode that clock is the oscillator that the analog loop steers. In bypass (test) mode it is the chosen reference, inverted. From that stage clock the tree makes a double-rate output, a bank of in-phase base-rate outputs, one inverted base-rate output and a half-rate output. A one-bit pre-divide can halve the stage clock before it reaches the tree. A lock status output passes on the loop's lock detector, but only while the loop is enabled.

All three incoming clocks are treated as slow signals and sampled on a fast block clock `clk`, each through its own synchronizer. Every divider stage is a toggle flip-flop that fires on the rising edge of the stage before it. All of these flip-flops advance on the same `clk` edge, so the base, inverted and half-rate edges line up exactly. Bypass mode has no lower frequency limit, which makes it usable for board-level testing with a slow tester clock.

Top module: `clkdist_tree`

## Requirements
- R1: `ref_sel` = 0 routes `ref0_clk` into the tree and `ref_sel` = 1 routes `ref1_clk`. Edges on the reference that is not selected change no output.
- R2: In loop mode (`pll_en` = 1) with `freq_sel` = 1, each rising edge of `osc_clk` is one stage edge. `dbl_clk` follows `osc_clk`, every base output divides it by 2 and `half_clk` divides it by 4.
- R3: With `freq_sel` = 0, a divide-by-2 flip-flop sits ahead of the tree, so every rate halves. In loop mode `dbl_clk` is `osc_clk`/2, the base outputs are `osc_clk`/4 and `half_clk` is `osc_clk`/8. A base output edge always comes with a rising edge of `dbl_clk`.
- R4: In bypass mode (`pll_en` = 0) with `freq_sel` = 1, the stage clock is the inverse of the selected reference. `dbl_clk` follows the inverted reference, the base outputs toggle on each falling reference edge (reference/2) and `half_clk` is reference/4.
- R5: In bypass mode with `freq_sel` = 0, `dbl_clk` is reference/2, the base outputs are reference/4 and `half_clk` is reference/8.
- R6: All `NUM_BASE` bits of `base_clk` are equal at every cycle. `half_clk` changes only in a cycle where `base_clk` rises.
- R7: `inv_clk` is always the complement of `base_clk`.
- R8: While `rst_n` is low at a `clk` edge (synchronous, active low), the outputs go to their reset levels: `dbl_clk`, `base_clk` and `half_clk` low, `inv_clk` high. This holds even when a source edge reaches the tree in that same cycle. After release, the first stage edge makes `base_clk` and `half_clk` rise and `inv_clk` fall.
- R9: `lock_o` equals `pll_en` AND the synchronized `lock_det`. It is low in the same cycle that `pll_en` is low, and it follows `lock_det` within `SYNC_STAGES` + 1 cycles.
- R10: In bypass mode, edges on `osc_clk` change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast block clock that samples all incoming clocks |
| rst_n | input | 1 | Synchronous active-low reset of the divider tree |
| ref0_clk | input | 1 | Reference clock 0 |
| ref1_clk | input | 1 | Reference clock 1 |
| ref_sel | input | 1 | Reference choice: 0 picks ref0_clk, 1 picks ref1_clk |
| freq_sel | input | 1 | 1 = no pre-divide, 0 = halve the stage clock |
| pll_en | input | 1 | 1 = loop mode (oscillator), 0 = bypass mode (inverted reference) |
| osc_clk | input | 1 | Oscillator clock from the analog loop |
| lock_det | input | 1 | Lock detector from the analog loop |
| dbl_clk | output | 1 | Double-rate output |
| base_clk | output | NUM_BASE | In-phase base-rate outputs |
| inv_clk | output | 1 | Inverted base-rate output |
| half_clk | output | 1 | Half-rate output |
| lock_o | output | 1 | Qualified lock status |

## Verification
Two things can land on the tree in the same `clk` cycle: a source edge leaving the synchronizers, and reset. The bench forces this by pulling `rst_n` low exactly at the sampling edge where a falling reference edge reaches the stage register. It then expects reset levels on every output, and expects the first stage edge after release to raise the base and half-rate outputs together. Apart from that, edges of the chosen source and of all outputs are counted under random half-periods for every combination of mode, pre-divide and reference choice. The sources that are not selected keep toggling during this, so any leak shows up in the counts.

// File: rtl/clkdist_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the clock distribution divider tree.
package clkdist_pkg;

    // Source of the stage clock feeding the divider tree.
    typedef enum logic {
        SRC_LOOP   = 1'b0,   // oscillator from the analog loop
        SRC_BYPASS = 1'b1    // inverted selected reference (test mode)
    } src_mode_e;

    // Number of raw clock inputs sampled by the source stage.
    localparam int unsigned RAW_CLK_COUNT = 3;

    // Next value of a toggle flip-flop given its advance event.
    function automatic logic toggle_next(input logic cur, input logic adv);
        return cur ^ adv;
    endfunction

endpackage

// File: rtl/clkdist_sync.sv
`timescale 1ns/1ps
// clkdist_sync: multi-flop synchronizer for a single slow level.
// Assumes the input stays put for at least two clk periods between changes.
// No reset: the chain simply tracks its input.
module clkdist_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the sampled level down the chain.
    always_ff @(posedge clk) begin
        chain_q[0] <= d;
        for (int i = 1; i < STAGES; i++) begin
            chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkdist_src.sv
`timescale 1ns/1ps
// clkdist_src: synchronizes both references and the oscillator. It picks the
// reference, then the stage clock (oscillator or inverted reference), registers
// that level and flags its rising edge.
// Assumes every raw clock half-period spans at least two clk periods.
module clkdist_src
    import clkdist_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref0_clk,
    input  logic ref1_clk,
    input  logic ref_sel,
    input  logic pll_en,
    input  logic osc_clk,
    output logic stage_lvl,
    output logic stage_rise,
    output logic run
);
    localparam int unsigned IDX_REF0 = 0;
    localparam int unsigned IDX_REF1 = 1;
    localparam int unsigned IDX_OSC  = 2;

    logic [RAW_CLK_COUNT-1:0] raw_clk;
    logic [RAW_CLK_COUNT-1:0] sync_clk;
    logic                     ref_pick;
    logic                     stage_in;
    logic                     stage_q;
    logic                     run_q;
    src_mode_e                mode;

    assign raw_clk[IDX_REF0] = ref0_clk;
    assign raw_clk[IDX_REF1] = ref1_clk;
    assign raw_clk[IDX_OSC]  = osc_clk;

    // One synchronizer per raw clock input.
    for (genvar g = 0; g < RAW_CLK_COUNT; g++) begin : g_sync
        clkdist_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .d   (raw_clk[g]),
            .q   (sync_clk[g])
        );
    end

    // Pick the reference, then the mode, then the stage clock level.
    always_comb begin
        ref_pick = ref_sel ? sync_clk[IDX_REF1] : sync_clk[IDX_REF0];
        mode     = pll_en ? SRC_LOOP : SRC_BYPASS;
        case (mode)
            SRC_BYPASS: stage_in = ~ref_pick;
            default:    stage_in = sync_clk[IDX_OSC];
        endcase
    end

    // Track the stage level every cycle, also in reset, so release makes no false edge.
    always_ff @(posedge clk) begin
        stage_q <= stage_in;
    end

    // Run flag: low in reset, high from the first cycle after release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
        end
    end

    assign stage_lvl  = stage_q;
    assign stage_rise = stage_in & ~stage_q;
    assign run        = run_q;
endmodule

// File: rtl/clkdist_div.sv
`timescale 1ns/1ps
// clkdist_div: optional divide-by-2 ahead of the tree, then the base bank,
// its inverted companion and the half-rate stage. Every stage is a toggle
// flip-flop that advances on the rising edge of the stage before it. All
// stages update on the same clk edge, so their edges coincide.
// Assumes freq_sel changes only while reset is held.
module clkdist_div
    import clkdist_pkg::*;
#(
    parameter int unsigned NUM_BASE = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                freq_sel,
    input  logic                stage_lvl,
    input  logic                stage_rise,
    input  logic                run,
    output logic                dbl_clk,
    output logic [NUM_BASE-1:0] base_clk,
    output logic                inv_clk,
    output logic                half_clk
);
    logic                pre_q;
    logic                dbl_rise;
    logic [NUM_BASE-1:0] base_q;
    logic                base_rise;
    logic                inv_q;
    logic                half_q;

    // Pre-divide toggle, used only when freq_sel is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= 1'b0;
        end else begin
            pre_q <= toggle_next(pre_q, stage_rise & ~freq_sel);
        end
    end

    // Rising edge of the double-rate level, the event that advances the base bank.
    assign dbl_rise = freq_sel ? stage_rise : (stage_rise & ~pre_q);

    // Base bank: one toggle flip-flop per output, all on the same event.
    for (genvar b = 0; b < NUM_BASE; b++) begin : g_base
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[b] <= 1'b0;
            end else begin
                base_q[b] <= toggle_next(base_q[b], dbl_rise);
            end
        end
    end

    // Inverted companion: its own flip-flop, reset high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q <= 1'b1;
        end else begin
            inv_q <= toggle_next(inv_q, dbl_rise);
        end
    end

    assign base_rise = dbl_rise & ~base_q[0];

    // Half-rate stage advances on a base rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else begin
            half_q <= toggle_next(half_q, base_rise);
        end
    end

    assign dbl_clk  = run & (freq_sel ? stage_lvl : pre_q);
    assign base_clk = base_q;
    assign inv_clk  = inv_q;
    assign half_clk = half_q;
endmodule

// File: rtl/clkdist_lock.sv
`timescale 1ns/1ps
// clkdist_lock: synchronizes the analog lock detector and masks it whenever
// the loop is disabled. pll_en is treated as a quasi-static control.
module clkdist_lock #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic pll_en,
    input  logic lock_det,
    output logic lock_o
);
    logic lock_s;

    clkdist_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
        .clk (clk),
        .d   (lock_det),
        .q   (lock_s)
    );

    assign lock_o = pll_en & lock_s;
endmodule

// File: rtl/clkdist_tree.sv
`timescale 1ns/1ps
// clkdist_tree: top of the clock distribution divider tree. Wires the source
// selection, the divider tree and the lock qualifier together.
// Assumes raw clock half-periods of at least two clk periods, and mode and
// pre-divide controls that change only under reset.
module clkdist_tree #(
    parameter int unsigned NUM_BASE    = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref0_clk,
    input  logic                ref1_clk,
    input  logic                ref_sel,
    input  logic                freq_sel,
    input  logic                pll_en,
    input  logic                osc_clk,
    input  logic                lock_det,
    output logic                dbl_clk,
    output logic [NUM_BASE-1:0] base_clk,
    output logic                inv_clk,
    output logic                half_clk,
    output logic                lock_o
);
    logic stage_lvl;
    logic stage_rise;
    logic run;

    clkdist_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref0_clk   (ref0_clk),
        .ref1_clk   (ref1_clk),
        .ref_sel    (ref_sel),
        .pll_en     (pll_en),
        .osc_clk    (osc_clk),
        .stage_lvl  (stage_lvl),
        .stage_rise (stage_rise),
        .run        (run)
    );

    clkdist_div #(.NUM_BASE(NUM_BASE)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .freq_sel   (freq_sel),
        .stage_lvl  (stage_lvl),
        .stage_rise (stage_rise),
        .run        (run),
        .dbl_clk    (dbl_clk),
        .base_clk   (base_clk),
        .inv_clk    (inv_clk),
        .half_clk   (half_clk)
    );

    clkdist_lock #(.SYNC_STAGES(SYNC_STAGES)) u_lock (
        .clk      (clk),
        .pll_en   (pll_en),
        .lock_det (lock_det),
        .lock_o   (lock_o)
    );
endmodule

// File: rtl/clkdist_tree_chk.sv
`timescale 1ns/1ps
// clkdist_tree_chk: assertion checker bound to clkdist_tree. It watches only
// the top-level ports.
module clkdist_tree_chk #(
    parameter int unsigned NUM_BASE = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pll_en,
    input logic                dbl_clk,
    input logic [NUM_BASE-1:0] base_clk,
    input logic                inv_clk,
    input logic                half_clk,
    input logic                lock_o
);
    logic rst_prev_q;
    logic seen_q;

    // Remember the reset level of the previous edge and that an edge has occurred.
    always_ff @(posedge clk) begin
        rst_prev_q <= rst_n;
        seen_q     <= 1'b1;
    end

    // R8: one edge after reset was sampled low, every output sits at its reset level.
    always_ff @(posedge clk) begin
        if (seen_q === 1'b1 && rst_prev_q === 1'b0) begin
            a_r8_reset_levels: assert (dbl_clk == 1'b0 && base_clk == '0 &&
                                       half_clk == 1'b0 && inv_clk == 1'b1)
                else $error("reset levels wrong");
        end
    end

    a_r6_base_bank_equal: assert property (@(posedge clk) disable iff (!rst_n)
        base_clk == {NUM_BASE{base_clk[0]}});

    a_r6_half_with_base_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(half_clk) |-> $rose(base_clk[0]));

    a_r7_inv_complement: assert property (@(posedge clk) disable iff (!rst_n)
        inv_clk == ~base_clk[0]);

    a_r3_base_edge_on_dbl_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(base_clk[0]) |-> $rose(dbl_clk));

    a_r9_lock_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> pll_en);
endmodule

bind clkdist_tree clkdist_tree_chk #(.NUM_BASE(NUM_BASE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pll_en   (pll_en),
    .dbl_clk  (dbl_clk),
    .base_clk (base_clk),
    .inv_clk  (inv_clk),
    .half_clk (half_clk),
    .lock_o   (lock_o)
);

// File: tb/test_clkdist_tree.sv
`timescale 1ns/1ps
// Bench for clkdist_tree: random half-periods on all raw clocks from a fixed
// seed, plus directed cases for reset collision, first edge and lock.
module test_clkdist_tree;
    localparam int unsigned NB = 5;
    localparam int unsigned SS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref0_clk = 1'b1, ref1_clk = 1'b1, osc_clk = 1'b0;
    logic          ref_sel = 1'b0, freq_sel = 1'b1, pll_en = 1'b1, lock_det = 1'b0;
    logic          dbl_clk, inv_clk, half_clk, lock_o;
    logic [NB-1:0] base_clk;

    int checks = 0;
    int fails  = 0;
    int cnt_dbl = 0, cnt_base = 0, cnt_inv = 0, cnt_half = 0, eq_err = 0;
    logic p_dbl = 1'b0, p_base = 1'b0, p_inv = 1'b0, p_half = 1'b0;
    bit   wd_hit = 1'b0;

    always #2.5 clk = ~clk;

    clkdist_tree #(.NUM_BASE(NB), .SYNC_STAGES(SS)) i_clkdist_tree (
        .clk(clk), .rst_n(rst_n), .ref0_clk(ref0_clk), .ref1_clk(ref1_clk),
        .ref_sel(ref_sel), .freq_sel(freq_sel), .pll_en(pll_en),
        .osc_clk(osc_clk), .lock_det(lock_det), .dbl_clk(dbl_clk),
        .base_clk(base_clk), .inv_clk(inv_clk), .half_clk(half_clk),
        .lock_o(lock_o)
    );

    // Count rising edges of every output and bank/companion mismatches, away from posedge.
    always @(negedge clk) begin
        if (dbl_clk === 1'b1 && p_dbl === 1'b0) cnt_dbl++;
        if (base_clk[0] === 1'b1 && p_base === 1'b0) cnt_base++;
        if (inv_clk === 1'b1 && p_inv === 1'b0) cnt_inv++;
        if (half_clk === 1'b1 && p_half === 1'b0) cnt_half++;
        if (rst_n && (base_clk !== {NB{base_clk[0]}} || inv_clk !== ~base_clk[0])) eq_err++;
        p_dbl = dbl_clk; p_base = base_clk[0]; p_inv = inv_clk; p_half = half_clk;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected rising-edge counts from the number of active source edges.
    function automatic int exp_dbl(input int e, input bit fs);
        return fs ? e : (e + 1) / 2;
    endfunction
    function automatic int exp_base(input int e, input bit fs);
        return (exp_dbl(e, fs) + 1) / 2;
    endfunction
    function automatic int exp_inv(input int e, input bit fs);
        return exp_dbl(e, fs) / 2;
    endfunction
    function automatic int exp_half(input int e, input bit fs);
        return (exp_base(e, fs) + 1) / 2;
    endfunction

    task automatic apply_reset(input bit pll, input bit fs, input bit rsel);
        @(negedge clk);
        rst_n = 1'b0; pll_en = pll; freq_sel = fs; ref_sel = rsel;
        osc_clk = 1'b0; ref0_clk = 1'b1; ref1_clk = 1'b1;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Toggle all raw clocks with random half-periods until nedges active source edges.
    task automatic run_case(input bit pll, input bit fs, input bit rsel, input int nedges);
        int h_osc, h_r0, h_r1, e;
        int s_dbl, s_base, s_inv, s_half, s_eq;
        string tag;
        apply_reset(pll, fs, rsel);
        s_dbl = cnt_dbl; s_base = cnt_base; s_inv = cnt_inv; s_half = cnt_half; s_eq = eq_err;
        h_osc = 2 + $urandom % 5; h_r0 = 2 + $urandom % 5; h_r1 = 2 + $urandom % 5;
        e = 0;
        while (e < nedges) begin
            @(negedge clk);
            h_osc--; h_r0--; h_r1--;
            if (h_osc == 0) begin
                osc_clk = ~osc_clk; h_osc = 2 + $urandom % 5;
                if (pll && osc_clk) e++;
            end
            if (h_r0 == 0) begin
                ref0_clk = ~ref0_clk; h_r0 = 2 + $urandom % 5;
                if (!pll && !rsel && !ref0_clk) e++;
            end
            if (h_r1 == 0) begin
                ref1_clk = ~ref1_clk; h_r1 = 2 + $urandom % 5;
                if (!pll && rsel && !ref1_clk) e++;
            end
        end
        repeat (12) @(negedge clk);
        if (pll) tag = fs ? "R2" : "R3";
        else     tag = fs ? "R4 R1 R10" : "R5 R1 R10";
        tag = $sformatf("%s pll=%0d fs=%0d sel=%0d", tag, pll, fs, rsel);
        check({tag, " dbl rises"},  cnt_dbl - s_dbl,   exp_dbl(e, fs));
        check({tag, " base rises"}, cnt_base - s_base, exp_base(e, fs));
        check({tag, " half rises"}, cnt_half - s_half, exp_half(e, fs));
        check({tag, " R7 inv rises"}, cnt_inv - s_inv, exp_inv(e, fs));
        check({tag, " R6 bank mismatches"}, eq_err - s_eq, 0);
    endtask

    task automatic main_flow();
        // R8: reset state
        apply_reset(1'b0, 1'b1, 1'b0);
        check("R8 reset dbl", int'(dbl_clk), 0);
        check("R8 reset base", int'(base_clk), 0);
        check("R8 reset half", int'(half_clk), 0);
        check("R8 reset inv", int'(inv_clk), 1);
        // R8/R4: first falling reference edge after release moves the whole tree
        @(negedge clk); ref0_clk = 1'b0;
        repeat (8) @(negedge clk);
        check("R8 first edge base", int'(base_clk), (1 << NB) - 1);
        check("R8 first edge half", int'(half_clk), 1);
        check("R8 first edge inv", int'(inv_clk), 0);
        check("R4 dbl is inverted reference", int'(dbl_clk), 1);
        // R8: reset meets a source edge at the same sampling edge
        ref0_clk = 1'b1;
        repeat (8) @(negedge clk);
        ref0_clk = 1'b0;
        repeat (SS) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 collision base", int'(base_clk), 0);
        check("R8 collision half", int'(half_clk), 0);
        check("R8 collision inv", int'(inv_clk), 1);
        check("R8 collision dbl", int'(dbl_clk), 0);
        // Directed ratio cases, all mode combinations and both reference choices
        run_case(1'b1, 1'b1, 1'b0, 40);
        run_case(1'b1, 1'b0, 1'b1, 41);
        run_case(1'b0, 1'b1, 1'b0, 37);
        run_case(1'b0, 1'b1, 1'b1, 38);
        run_case(1'b0, 1'b0, 1'b0, 45);
        run_case(1'b0, 1'b0, 1'b1, 43);
        // Random mix
        for (int k = 0; k < 8; k++) begin
            run_case(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1 + $urandom % 60);
        end
        // R9: lock qualification, sources idle
        apply_reset(1'b1, 1'b1, 1'b0);
        lock_det = 1'b1;
        repeat (SS + 2) @(negedge clk);
        check("R9 lock follows detector", int'(lock_o), 1);
        pll_en = 1'b0;
        #1;
        check("R9 lock masked by disable", int'(lock_o), 0);
        @(negedge clk);
        pll_en = 1'b1; lock_det = 1'b0;
        repeat (SS + 2) @(negedge clk);
        check("R9 lock drops with detector", int'(lock_o), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fork
            main_flow();
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule